// File: doc/BRIEF.md
# Stuck Two-Wire Bus Detector and Recovery Sequencer

This block watches the sampled SDA and SCL levels of a local two-wire bus. It detects a line that has been held low for too long. A counter advances on every system clock cycle in which either line is low, and it returns to zero only when both lines are high at the same time. When the count reaches the configured limit, the block declares the bus stuck. It raises a flag that tells the surrounding logic to stop driving the bus normally, and it emits a single-cycle request to notify the far side of the isolation link.

After a guard delay the block tries to free the bus. It clocks SCL through open-drain pull-down requests. The clocking stops as soon as SDA is seen released, or once the maximum number of clocks has been sent. It then forms a stop condition: SDA is pulled low while SCL is low, SCL is released, and after half a clock period SDA is released. The stuck flag stays up until both lines are seen high after this sequence. Reconnection is then left to the connection logic outside this block.

Every duration is a parameter counted in system clock cycles. Deasserting the enable input holds the whole block idle. This covers undervoltage, over-temperature and low-power shutdown.

Top module: `stuck_bus_recovery`

## Requirements
- R1: The low-time counter advances on each cycle with SDA or SCL low, and it restarts from zero whenever both lines are sampled high. A low stretch of STUCK_CYC-1 cycles that is broken by a single high cycle, and then followed by another STUCK_CYC-1 low cycles, never declares the bus stuck.
- R2: `stuck` (1 = stuck) rises right after the STUCK_CYC-th consecutive clock edge at which a low line was sampled, and not one edge earlier.
- R3: `notify` is high for exactly one cycle per stuck event, in the cycle in which `stuck` first reads high.
- R4: The first SCL pull-down request (`scl_pd` = 1 means drive SCL low) rises exactly WAIT_CYC cycles after `stuck` rises. Neither pull-down is requested before then.
- R5: Each recovery clock holds `scl_pd` high for HALF_CYC cycles and low for HALF_CYC cycles.
- R6: SDA is sampled in the last released cycle of each clock. Clocking ends after the first clock in which SDA reads high, or after NUM_CLK clocks, whichever comes first.
- R7: The stop is formed as follows. `sda_pd` (1 = drive SDA low) rises in the same cycle as `scl_pd`. `scl_pd` falls HALF_CYC cycles later. `sda_pd` falls HALF_CYC cycles after that.
- R8: After the stop, `stuck` stays high while either line is low, and it falls one cycle after both lines are first sampled high.
- R9: With `en` low, the counter is held cleared and no stuck event occurs. Dropping `en` during recovery releases `scl_pd`, `sda_pd`, `stuck` and `notify` at the next edge.
- R10: The synchronous active-high reset leaves all four outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Block active when high; low holds it idle |
| sda_in | input | 1 | Sampled SDA level |
| scl_in | input | 1 | Sampled SCL level |
| scl_pd | output | 1 | Request to pull SCL low |
| sda_pd | output | 1 | Request to pull SDA low |
| stuck | output | 1 | Bus declared stuck; normal driving must stop |
| notify | output | 1 | One-cycle request to notify the remote side |

## Verification
The bench builds the block with STUCK_CYC=20, WAIT_CYC=8, HALF_CYC=3 and NUM_CLK=16. These values keep each complete recovery to a couple of hundred cycles, so every possible SDA release point can be swept in one run. The sweep runs from release after the first clock through release after the sixteenth, plus a holder that never lets go. This covers both the early exit and the clock limit, and the bench computes the expected clock count, edge positions and stop timing arithmetically for each case. Short STUCK_CYC and WAIT_CYC values make the exact stuck edge, the broken-low-stretch case, an SCL-held cause and enable removal in mid-sequence cheap to exercise cycle by cycle.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_HOLD     = 3'd1,
        ST_CLK_LO   = 3'd2,
        ST_CLK_HI   = 3'd3,
        ST_STOP_SET = 3'd4,
        ST_STOP_REL = 3'd5,
        ST_SETTLE   = 3'd6
    } rec_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
    } pulldown_t;

    function automatic pulldown_t drive_for(rec_state_e s);
        pulldown_t p;
        p.scl = (s == ST_CLK_LO) || (s == ST_STOP_SET);
        p.sda = (s == ST_STOP_SET) || (s == ST_STOP_REL);
        return p;
    endfunction

    function automatic logic bus_released(logic sda, logic scl);
        return sda & scl;
    endfunction

endpackage

// File: rtl/low_timer.sv
module low_timer
    import busrec_pkg::*;
#(
    parameter int STUCK_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic arm,
    input  logic sda,
    input  logic scl,
    output logic trip
);
    localparam int CW = $clog2(STUCK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(STUCK_CYC - 1);

    logic [CW-1:0] cnt;
    logic          low_any;

    assign low_any = !bus_released(sda, scl);
    assign trip    = en && arm && low_any && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !en || !arm || !low_any) begin
            cnt <= '0;
        end else if (!trip) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: both lines high clears the count
    p_timer_clear_r1: assert property (@(posedge clk) disable iff (rst)
        bus_released(sda, scl) |=> (cnt == '0));

    // R1: a low cycle while armed advances the count by one
    p_timer_step_r1: assert property (@(posedge clk) disable iff (rst)
        (en && arm && low_any && !trip) |=> (cnt == $past(cnt) + 1'b1));

    // R9: disabled keeps the count at zero
    p_timer_off_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));

endmodule

// File: rtl/recovery_fsm.sv
module recovery_fsm
    import busrec_pkg::*;
#(
    parameter int WAIT_CYC = 8,
    parameter int HALF_CYC = 3,
    parameter int NUM_CLK  = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       trip,
    input  logic       sda,
    input  logic       scl,
    output rec_state_e state,
    output pulldown_t  pd,
    output logic       notify
);
    localparam int MAXD = (WAIT_CYC > HALF_CYC) ? WAIT_CYC : HALF_CYC;
    localparam int TW   = $clog2(MAXD + 1);
    localparam int KW   = $clog2(NUM_CLK + 1);
    localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);
    localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYC - 1);
    localparam logic [KW-1:0] CLK_LAST = KW'(NUM_CLK - 1);

    logic [TW-1:0] tmr;
    logic [KW-1:0] ccnt;
    logic          tmr_done;

    assign tmr_done = (tmr == '0);
    assign pd       = drive_for(state);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state  <= ST_IDLE;
            tmr    <= '0;
            ccnt   <= '0;
            notify <= 1'b0;
        end else begin
            notify <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (trip) begin
                        state  <= ST_HOLD;
                        tmr    <= WAIT_LD;
                        notify <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tmr_done) begin
                        state <= ST_CLK_LO;
                        tmr   <= HALF_LD;
                        ccnt  <= '0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_CLK_LO: begin
                    if (tmr_done) begin
                        state <= ST_CLK_HI;
                        tmr   <= HALF_LD;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_CLK_HI: begin
                    if (tmr_done) begin
                        ccnt <= ccnt + 1'b1;
                        tmr  <= HALF_LD;
                        if (sda || (ccnt == CLK_LAST)) begin
                            state <= ST_STOP_SET;
                        end else begin
                            state <= ST_CLK_LO;
                        end
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_STOP_SET: begin
                    if (tmr_done) begin
                        state <= ST_STOP_REL;
                        tmr   <= HALF_LD;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_STOP_REL: begin
                    if (tmr_done) begin
                        state <= ST_SETTLE;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (bus_released(sda, scl)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: the notify request lasts one cycle
    p_notify_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        notify |=> !notify);

    // R2: notify appears only on entry into the guard delay
    p_notify_entry_r2: assert property (@(posedge clk) disable iff (rst)
        notify |-> (state == ST_HOLD));

    // R6: never more clocks than the limit
    p_clk_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CLK_LO) |-> (ccnt < KW'(NUM_CLK)));

    // R7: SDA is pulled only while SCL is pulled
    p_stop_start_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(pd.sda) |-> pd.scl);

    // R7: SDA is released only with SCL released
    p_stop_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(pd.sda) |-> !pd.scl);

    // R8: settle holds while any line is low
    p_settle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (en && state == ST_SETTLE && !bus_released(sda, scl)) |=> (state == ST_SETTLE));

    // R9: disable returns to idle
    p_disable_r9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == ST_IDLE) && !notify);

endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery
    import busrec_pkg::*;
#(
    parameter int STUCK_CYC = 1850000,
    parameter int WAIT_CYC  = 2000,
    parameter int HALF_CYC  = 250,
    parameter int NUM_CLK   = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sda_in,
    input  logic scl_in,
    output logic scl_pd,
    output logic sda_pd,
    output logic stuck,
    output logic notify
);
    rec_state_e state;
    pulldown_t  pd;
    logic       trip;
    logic       armed;

    assign armed = (state == ST_IDLE);

    low_timer #(
        .STUCK_CYC(STUCK_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .arm (armed),
        .sda (sda_in),
        .scl (scl_in),
        .trip(trip)
    );

    recovery_fsm #(
        .WAIT_CYC(WAIT_CYC),
        .HALF_CYC(HALF_CYC),
        .NUM_CLK (NUM_CLK)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .trip  (trip),
        .sda   (sda_in),
        .scl   (scl_in),
        .state (state),
        .pd    (pd),
        .notify(notify)
    );

    assign scl_pd = pd.scl;
    assign sda_pd = pd.sda;
    assign stuck  = !armed;

    // R9: no pull-down request unless the bus is declared stuck
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !stuck |-> (!scl_pd && !sda_pd));

    // R2: stuck only rises together with a notify request
    p_stuck_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(stuck) |-> notify);

endmodule

// File: tb/tb_stuck_bus_recovery.sv
module tb_stuck_bus_recovery;
    localparam int N  = 20;
    localparam int W  = 8;
    localparam int H  = 3;
    localparam int NC = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic sda_hold = 1'b0;
    logic scl_hold = 1'b0;
    int   scen_id  = 0;
    int   freed_id = -1;
    int   release_after = 0;
    logic bus_sda, bus_scl;
    logic scl_pd, sda_pd, stuck, notify;

    assign bus_sda = !sda_pd && !(sda_hold && (freed_id != scen_id));
    assign bus_scl = !scl_pd && !scl_hold;

    stuck_bus_recovery #(
        .STUCK_CYC(N), .WAIT_CYC(W), .HALF_CYC(H), .NUM_CLK(NC)
    ) dut (
        .clk(clk), .rst(rst), .en(en),
        .sda_in(bus_sda), .scl_in(bus_scl),
        .scl_pd(scl_pd), .sda_pd(sda_pd), .stuck(stuck), .notify(notify)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // monitor of output edges, sampled on the falling clock edge
    int t_stuck = 0, t_stuck_fall = 0, t_first = 0, t_rise = 0, t_fall = 0;
    int t_sda_rise = 0, t_scl_stop_fall = 0, t_sda_fall = 0;
    int n_evt_clk = 0, n_notify = 0, werr = 0;
    bit sda_rise_with_scl = 0;
    bit p_scl = 0, p_sda = 0, p_stuck = 0, p_notify = 0;

    always @(negedge clk) begin
        if (notify && !p_notify) n_notify++;
        if (stuck && !p_stuck) begin
            t_stuck   = cyc;
            n_evt_clk = 0;
        end
        if (!stuck && p_stuck) t_stuck_fall = cyc;
        if (scl_pd && !p_scl) begin
            if (sda_pd) begin
                if (cyc - t_fall != H) werr++;
            end else begin
                n_evt_clk++;
                if (n_evt_clk == 1) t_first = cyc;
                else if (cyc - t_fall != H) werr++;
            end
            t_rise = cyc;
        end
        if (!scl_pd && p_scl) begin
            if (sda_pd) begin
                t_scl_stop_fall = cyc;
            end else begin
                if (cyc - t_rise != H) werr++;
                if (n_evt_clk >= release_after) freed_id = scen_id;
            end
            t_fall = cyc;
        end
        if (sda_pd && !p_sda) begin
            t_sda_rise        = cyc;
            sda_rise_with_scl = scl_pd;
        end
        if (!sda_pd && p_sda) t_sda_fall = cyc;
        p_scl    = scl_pd;
        p_sda    = sda_pd;
        p_stuck  = stuck;
        p_notify = notify;
    end

    // checks the exact stuck edge after a hold that began at a falling edge
    task automatic expect_trip();
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        chk(stuck == 1'b0, "R2 early", stuck, 0);
        @(posedge clk);
        @(negedge clk);
        chk(stuck == 1'b1, "R2 on limit", stuck, 1);
        chk(notify == 1'b1, "R3 notify with stuck", notify, 1);
        @(negedge clk);
        chk(notify == 1'b0, "R3 notify one cycle", notify, 0);
    endtask

    task automatic check_recovery(input int expclk, input int w0, input int nn0);
        repeat (W + 2 * H * (expclk + 1) + 6) @(negedge clk);
        chk(n_evt_clk == expclk, "R6 clock count", n_evt_clk, expclk);
        chk(werr == w0, "R5 clock widths", werr - w0, 0);
        chk(t_first - t_stuck == W, "R4 guard delay", t_first - t_stuck, W);
        chk(t_sda_rise - t_first == 2 * H * expclk, "R7 stop start",
            t_sda_rise - t_first, 2 * H * expclk);
        chk(sda_rise_with_scl == 1'b1, "R7 SDA set with SCL low", sda_rise_with_scl, 1);
        chk(t_scl_stop_fall - t_sda_rise == H, "R7 SCL release",
            t_scl_stop_fall - t_sda_rise, H);
        chk(t_sda_fall - t_scl_stop_fall == H, "R7 SDA release",
            t_sda_fall - t_scl_stop_fall, H);
        chk(n_notify - nn0 == 1, "R3 one notify per event", n_notify - nn0, 1);
    endtask

    task automatic run_sda_case(input int k);
        int w0, nn0, expclk;
        expclk = (k < NC) ? k : NC;
        @(negedge clk);
        w0 = werr;
        nn0 = n_notify;
        release_after = k;
        scen_id++;
        sda_hold = 1'b1;
        expect_trip();
        check_recovery(expclk, w0, nn0);
        if (k <= NC) begin
            chk(stuck == 1'b0, "R8 cleared", stuck, 0);
            chk(t_stuck_fall - t_sda_fall == 1, "R8 clear timing",
                t_stuck_fall - t_sda_fall, 1);
        end else begin
            chk(stuck == 1'b1, "R8 held while SDA low", stuck, 1);
            sda_hold = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(stuck == 1'b0, "R8 clears after release", stuck, 0);
        end
        sda_hold = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
        chk(scl_pd == 1'b0, "R10 reset scl_pd", scl_pd, 0);
        chk(sda_pd == 1'b0, "R10 reset sda_pd", sda_pd, 0);
        chk(stuck == 1'b0, "R10 reset stuck", stuck, 0);
        chk(notify == 1'b0, "R10 reset notify", notify, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: broken low stretch never trips
        begin
            int nn0;
            nn0 = n_notify;
            scen_id++;
            release_after = 100;
            sda_hold = 1'b1;
            repeat (N - 1) @(negedge clk);
            sda_hold = 1'b0;
            @(negedge clk);
            sda_hold = 1'b1;
            repeat (N - 1) @(negedge clk);
            chk(stuck == 1'b0, "R1 restart on high", stuck, 0);
            sda_hold = 1'b0;
            repeat (3) @(negedge clk);
            chk(n_notify == nn0, "R1 no notify", n_notify - nn0, 0);
        end

        // R6: sweep every release point plus a holder that never lets go
        for (int k = 1; k <= NC + 1; k++) begin
            run_sda_case(k);
        end

        // R2/R6: SCL held low with SDA high, one clock expected
        begin
            int w0, nn0;
            @(negedge clk);
            w0 = werr;
            nn0 = n_notify;
            release_after = 0;
            scl_hold = 1'b1;
            expect_trip();
            scl_hold = 1'b0;
            check_recovery(1, w0, nn0);
            chk(stuck == 1'b0, "R8 cleared after SCL case", stuck, 0);
            repeat (4) @(negedge clk);
        end

        // R9: disabled block ignores a long low
        begin
            int nn0;
            nn0 = n_notify;
            en = 1'b0;
            scen_id++;
            release_after = 100;
            sda_hold = 1'b1;
            repeat (3 * N) @(negedge clk);
            chk(stuck == 1'b0, "R9 no stuck while disabled", stuck, 0);
            chk(n_notify == nn0, "R9 no notify while disabled", n_notify - nn0, 0);
            sda_hold = 1'b0;
            @(negedge clk);
            en = 1'b1;
            repeat (3) @(negedge clk);
        end

        // R9: disable in the middle of clocking
        begin
            @(negedge clk);
            scen_id++;
            release_after = 100;
            sda_hold = 1'b1;
            expect_trip();
            repeat (W - 1) @(negedge clk);
            chk(scl_pd == 1'b1, "R4 first clock low phase", scl_pd, 1);
            en = 1'b0;
            @(posedge clk);
            @(negedge clk);
            chk(scl_pd == 1'b0, "R9 scl_pd released", scl_pd, 0);
            chk(sda_pd == 1'b0, "R9 sda_pd released", sda_pd, 0);
            chk(stuck == 1'b0, "R9 stuck released", stuck, 0);
            chk(notify == 1'b0, "R9 notify low", notify, 0);
            sda_hold = 1'b0;
            en = 1'b1;
            repeat (3) @(negedge clk);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule